// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers a parameterised number of interrupt inputs into a latched request vector and turns them into a single interrupt line toward a processor. Each request bit is set by a rising edge on its input. Software can also set request bits on purpose by writing a force word. It acknowledges requests by writing an acknowledge word. A per-source mask register selects which requests count as pending. A global gate decides whether pending work reaches the processor. That gate is opened and closed by writes to two separate addresses, and its state can be read back.

Software reaches the controller through a simple chip-select slave port. Every access completes in the cycle it is presented, so no wait states are ever inserted. The force, acknowledge, gate-open and gate-close addresses hold no storage. A write to one of them produces a one-cycle strobe that carries the written bits.

Top module: `irq_hub`

## Requirements
- R1: After reset the request vector, mask register and gate flag are all zero, `cpu_irq` is low, and reads of word addresses 0, 1 and 7 return 0.
- R2: `ready` is high in every cycle in which `sel` is high, so each read or write completes in that same cycle.
- R3: Word address 1 is the read/write mask register with one bit per source (bit i for source i). Write data bits at or above NUM_SRC are discarded, and those bits read back as zero.
- R4: A rising edge on `src_i[i]` sets request bit i at the next clock edge. A source that is held high after its bit has been acknowledged does not set the bit again.
- R5: A write to word address 2 sets every request bit whose data bit is 1. The request vector is read at word address 0.
- R6: A write to word address 3 clears every request bit whose data bit is 1. If a bit is set and cleared in the same cycle, it ends up set.
- R7: A read of word address 4 returns the request vector ANDed with the mask register.
- R8: A write to word address 5 with data bit 0 set raises the gate flag. A write to word address 6 with data bit 0 set lowers it. Such a write with bit 0 clear leaves the flag unchanged. The flag reads back as bit 0 of word address 7.
- R9: `cpu_irq` is high exactly when at least one pending bit is 1 and the gate flag is 1.
- R10: Reads of the strobe addresses 2, 3, 5 and 6 return zero. So do reads of any address above 7, and `rdata` is zero whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| sel | input | 1 | Slave chip select |
| addr | input | ADDR_W | Word address |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Access complete, same cycle |
| rdata | output | DATA_W | Read data, combinational from the address |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
Two events can land on the same request bit in one cycle: a rising source edge, which sets the bit, and an acknowledge write, which clears it. The bench first brings the source low. It then raises that source in exactly the cycle that carries the acknowledge write for the same bit, and reads the request word back afterwards. The bit must still read as 1, and the acknowledge must still clear other bits in the same word.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Word map of the slave port; the software view depends on these values.
  typedef enum logic [2:0] {
    WA_REQ   = 3'd0,
    WA_MASK  = 3'd1,
    WA_FORCE = 3'd2,
    WA_ACK   = 3'd3,
    WA_PEND  = 3'd4,
    WA_GON   = 3'd5,
    WA_GOFF  = 3'd6,
    WA_GSTAT = 3'd7
  } word_addr_e;

  localparam int MAP_BITS = 3;

endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] last_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic last_d;

    always_comb begin
      last_d   = src_i[g];
      rise_o[g] = src_i[g] & ~last_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q[g] <= 1'b0;
      else        last_q[g] <= last_d;
    end
  end

endmodule

// File: rtl/irq_hub_regif.sv
module irq_hub_regif
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] req_vec,
  input  logic [NUM_SRC-1:0] pend_vec,
  input  logic               allowed,
  output logic [NUM_SRC-1:0] mask_vec,
  output logic [NUM_SRC-1:0] force_stb,
  output logic [NUM_SRC-1:0] ack_stb,
  output logic               gon_stb,
  output logic               goff_stb,
  output logic               ready,
  output logic [DATA_W-1:0]  rdata
);

  localparam int HI_BITS = ADDR_W - MAP_BITS;

  logic               in_map;
  word_addr_e         waddr;
  logic               wr_hit;
  logic               rd_hit;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] mask_d;
  logic               mask_ce;
  logic [NUM_SRC-1:0] mask_q;
  logic               unused_ok;

  // Address decode: upper address bits must be zero to hit the map.
  if (HI_BITS > 0) begin : g_hi
    assign in_map = (addr[ADDR_W-1:MAP_BITS] == '0);
  end else begin : g_nohi
    assign in_map = 1'b1;
  end

  assign waddr  = word_addr_e'(addr[MAP_BITS-1:0]);
  assign wr_hit = sel & wr_en & in_map;
  assign rd_hit = sel & rd_en & in_map;
  assign wbits  = wdata[NUM_SRC-1:0];
  assign ready  = sel;

  // Write-only strobes carry the written bits for one cycle.
  always_comb begin
    force_stb = '0;
    ack_stb   = '0;
    gon_stb   = 1'b0;
    goff_stb  = 1'b0;
    if (wr_hit) begin
      case (waddr)
        WA_FORCE: force_stb = wbits;
        WA_ACK:   ack_stb   = wbits;
        WA_GON:   gon_stb   = wdata[0];
        WA_GOFF:  goff_stb  = wdata[0];
        default: ;
      endcase
    end
  end

  // Mask register: next state and clock enable.
  always_comb begin
    mask_ce = wr_hit && (waddr == WA_MASK);
    mask_d  = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_vec = mask_q;

  // Read mux, zero-extended to the bus width.
  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (waddr)
        WA_REQ:   rdata = DATA_W'(req_vec);
        WA_MASK:  rdata = DATA_W'(mask_q);
        WA_PEND:  rdata = DATA_W'(pend_vec);
        WA_GSTAT: rdata = DATA_W'(allowed);
        default:  rdata = '0;
      endcase
    end
  end

  assign unused_ok = ^wdata;

endmodule

// File: rtl/irq_hub_core.sv
module irq_hub_core #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] force_stb,
  input  logic [NUM_SRC-1:0] ack_stb,
  input  logic [NUM_SRC-1:0] mask_vec,
  input  logic               gon_stb,
  input  logic               goff_stb,
  output logic [NUM_SRC-1:0] req_vec,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic               allowed,
  output logic               cpu_irq
);

  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] req_d;
  logic               allow_q;
  logic               allow_d;
  logic               allow_ce;

  // Per-bit latch: set terms are applied after the clear term, so set wins.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_req
    always_comb begin
      req_d[g] = (req_q[g] & ~ack_stb[g]) | rise[g] | force_stb[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // Gate flag: separate open and close strobes from distinct addresses.
  always_comb begin
    allow_ce = gon_stb | goff_stb;
    allow_d  = gon_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        allow_q <= 1'b0;
    else if (allow_ce) allow_q <= allow_d;
  end

  assign req_vec  = req_q;
  assign pend_vec = req_q & mask_vec;
  assign allowed  = allow_q;
  assign cpu_irq  = allow_q & (|pend_vec);

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic               ready,
  output logic [DATA_W-1:0]  rdata,
  output logic               cpu_irq
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] force_stb;
  logic [NUM_SRC-1:0] ack_stb;
  logic [NUM_SRC-1:0] mask_vec;
  logic [NUM_SRC-1:0] req_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic               gon_stb;
  logic               goff_stb;
  logic               allowed;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_hub_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irq_hub_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel       (sel),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .req_vec   (req_vec),
    .pend_vec  (pend_vec),
    .allowed   (allowed),
    .mask_vec  (mask_vec),
    .force_stb (force_stb),
    .ack_stb   (ack_stb),
    .gon_stb   (gon_stb),
    .goff_stb  (goff_stb),
    .ready     (ready),
    .rdata     (rdata)
  );

  irq_hub_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rise      (rise),
    .force_stb (force_stb),
    .ack_stb   (ack_stb),
    .mask_vec  (mask_vec),
    .gon_stb   (gon_stb),
    .goff_stb  (goff_stb),
    .req_vec   (req_vec),
    .pend_vec  (pend_vec),
    .allowed   (allowed),
    .cpu_irq   (cpu_irq)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               sel,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wdata,
  input logic               ready,
  input logic               cpu_irq,
  input logic [NUM_SRC-1:0] req_vec,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic               allowed
);

  logic [NUM_SRC-1:0] src_seen_q;
  logic [NUM_SRC-1:0] new_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_seen_q <= '0;
    else        src_seen_q <= src_i;
  end
  assign new_rise = src_i & ~src_seen_q;

  // R2
  ready_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> ready);

  // R4
  rise_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_rise) |=> ((req_vec & $past(new_rise)) == $past(new_rise)));

  // R7
  pend_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~mask_vec) == '0));

  // R8
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == ADDR_W'(6) && wdata[0]) |=> !allowed);

  // R8
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == ADDR_W'(5) && wdata[0]) |=> allowed);

  // R9
  line_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !allowed |-> !cpu_irq);

endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .src_i    (src_i),
  .sel      (sel),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .ready    (ready),
  .cpu_irq  (cpu_irq),
  .req_vec  (req_vec),
  .mask_vec (mask_vec),
  .pend_vec (pend_vec),
  .allowed  (allowed)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

  localparam int NUM_SRC = 6;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;

  logic               clk;
  logic               rst_n;
  logic [NUM_SRC-1:0] src_i;
  logic               sel;
  logic [ADDR_W-1:0]  addr;
  logic               rd_en;
  logic               wr_en;
  logic [DATA_W-1:0]  wdata;
  logic               ready;
  logic [DATA_W-1:0]  rdata;
  logic               cpu_irq;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  int n_run;
  int n_fail;
  bit done;

  irq_hub #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_hub (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .sel     (sel),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .ready   (ready),
    .rdata   (rdata),
    .cpu_irq (cpu_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [NUM_SRC-1:0] s);
    @(posedge clk); #1;
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d; src_i = s;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                        input string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk); #1;
    sel = 1'b1; rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic set_src(input logic [NUM_SRC-1:0] s);
    @(posedge clk); #1;
    src_i = s;
  endtask

  // Monitor: compares each read against the queued expectation mid-cycle.
  always @(negedge clk) begin
    if (sel && rd_en) begin
      if (exp_q.size() == 0) begin
        check("monitor", 32'd1, 32'd0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, rdata, it.exp);
        check("R2 ready", {31'd0, ready}, 32'd1);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    src_i = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    bus_rd(3'd0, 32'd0, "R1 req");
    bus_rd(3'd1, 32'd0, "R1 mask");
    bus_rd(3'd7, 32'd0, "R1 gate");
    check("R10 rdata idle", rdata, 32'd0);

    // R3 mask keeps only NUM_SRC bits
    bus_wr(3'd1, 32'hFFFF_FFFF, 6'h00);
    bus_rd(3'd1, 32'h0000_003F, "R3 mask");

    // R5 force sets bits, force address reads zero (R10)
    bus_wr(3'd2, 32'h0000_0005, 6'h00);
    bus_rd(3'd0, 32'h0000_0005, "R5 req");
    bus_rd(3'd2, 32'd0, "R10 force rd");

    // R7 pending is masked
    bus_wr(3'd1, 32'h0000_0004, 6'h00);
    bus_rd(3'd4, 32'h0000_0004, "R7 pend");
    check("R9 gate closed", {31'd0, cpu_irq}, 32'd0);

    // R8 open gate, R9 line rises
    bus_wr(3'd5, 32'h0000_0001, 6'h00);
    check("R9 gate open", {31'd0, cpu_irq}, 32'd1);
    bus_rd(3'd7, 32'h0000_0001, "R8 gate rd");

    // R6 acknowledge
    bus_wr(3'd3, 32'h0000_0005, 6'h00);
    check("R9 after ack", {31'd0, cpu_irq}, 32'd0);
    bus_rd(3'd0, 32'd0, "R6 ack");

    // R4 rising edge latches; held level does not relatch
    set_src(6'h08);
    bus_rd(3'd0, 32'h0000_0008, "R4 rise");
    bus_wr(3'd3, 32'h0000_0008, 6'h08);
    bus_rd(3'd0, 32'd0, "R4 held level");

    // R6 set wins: rising edge on bit 1 in the ack cycle of bit 1 and bit 2
    set_src(6'h00);
    bus_wr(3'd2, 32'h0000_0006, 6'h00);
    bus_wr(3'd3, 32'h0000_0006, 6'h02);
    bus_rd(3'd0, 32'h0000_0002, "R6 set wins");

    // R8 close gate; write with bit 0 clear has no effect
    bus_wr(3'd6, 32'h0000_0001, 6'h02);
    bus_rd(3'd7, 32'd0, "R8 gate closed");
    bus_wr(3'd5, 32'h0000_0002, 6'h02);
    bus_rd(3'd7, 32'd0, "R8 bit0 clear");
    check("R9 closed line", {31'd0, cpu_irq}, 32'd0);

    // R10 strobe addresses read zero
    bus_rd(3'd3, 32'd0, "R10 ack rd");
    bus_rd(3'd5, 32'd0, "R10 gon rd");
    bus_rd(3'd6, 32'd0, "R10 goff rd");

    repeat (2) @(posedge clk);
    check("queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule